// File: doc/BRIEF.md
# Edge-Counting Subcarrier Bit Demodulator

This block recovers a short tag reply, at most 16 bits, from a digitized input that has already been thresholded with hysteresis. The reply carries no start, stop or length marker, so the caller states the number of bits it expects. A load-modulation subcarrier in a bit slot shows up as many level changes of the input. A quiet slot shows almost none. The block counts the level changes in each fixed slot and compares the count with an acceptance band.

A `start` strobe marks the moment the reader's own frame ended. All slot timing counts `tick_en` pulses from that moment. The first slot opens after a fixed lead time, and the slots that follow are back to back. While it waits, the block steps an external keystream generator: two steps are always discarded, and then, if decryption is requested, one keystream bit per expected bit is captured into a mask. That mask is XORed into the result. When the last slot closes, the block gives a one-cycle `done` pulse together with `tick_clear`, which tells the shared tick counter to restart so that the next reader frame is timed from there.

The controller has six states:
- ST_IDLE: waits for `start`.
- ST_SKIP: discards two keystream steps.
- ST_GRAB: captures the mask bits, when decryption is on.
- ST_WAIT: waits for the first slot to open.
- ST_WIN: counts edges and decides each bit.
- ST_DONE: gives the one-cycle finish pulse.

Its transitions are:
- IDLE to SKIP on `start`.
- SKIP to GRAB after the second step, when decryption is on and at least one bit is expected. Otherwise SKIP goes to WAIT.
- GRAB to WAIT after the last mask bit.
- WAIT to WIN when the first slot opens. If zero bits were requested, WAIT goes to DONE instead.
- WIN to DONE when the last slot closes.
- DONE to IDLE unconditionally.

Top module: `subcarrier_edge_demod`

## Requirements
- R1: `start` is accepted only in the idle state. A `start` during a reception has no effect on that reception. `word` and `nbits` keep their values from one `done` until the next accepted `start`.
- R2: Only cycles with `tick_en` high are counted. Slot 0 opens 490 counted ticks after the accepted `start`. Slot i closes 150·(i+1) ticks later, with no gap between slots. `done` is high in the cycle that follows the edge at tick 490 + 150·n, where n is the clamped bit count.
- R3: Inside a slot, every change of the synchronized input adds one to that slot's edge count. The compared level starts at 0 for every frame, so an input that is already high at frame start counts one edge in slot 0.
- R4: A slot decodes as 1 when its edge count is greater than 20 and less than 60. Counts of 20 or lower, and of 60 or higher, decode as 0.
- R5: The number of bits received is `req_bits` limited to 16, and `nbits` reports that number. Bits of `word` at or above `nbits` are 0.
- R6: Slot i writes bit i of `word`, so the first slot lands in the least significant bit.
- R7: After `start`, `ks_step` pulses exactly 2 + (`decrypt` ? n : 0) times before the first slot opens. Each mask bit is `ks_bit` as sampled in the same cycle as a `ks_step` pulse. Mask bit i is taken at the (3+i)-th pulse.
- R8: When `decrypt` is set, `word` is the decoded slot bits XOR the mask. When `decrypt` is clear, `word` is the decoded slot bits unchanged.
- R9: `done` and `tick_clear` are high together for exactly one cycle per frame.
- R10: During reset and just after it, `done`, `tick_clear`, `ks_step`, `word` and `nbits` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timing tick from the shared tick counter |
| start | input | 1 | End of the reader frame; starts a reception |
| req_bits | input | 5 | Number of bits expected (clamped to 16) |
| decrypt | input | 1 | Apply the keystream mask |
| rx_raw | input | 1 | Thresholded receive level, asynchronous |
| ks_bit | input | 1 | Current keystream bit |
| ks_step | output | 1 | Advance the keystream generator by one step |
| word | output | 16 | Received bits, least significant bit first |
| nbits | output | 5 | Number of bits received |
| done | output | 1 | One-cycle end-of-reception pulse |
| tick_clear | output | 1 | Restart the shared tick counter |

## Verification
The bench places edge counts of 20, 21, 59 and 60 on both sides of the acceptance band. A design with an off-by-one comparison would flip those bits. Done timing is checked to the exact cycle with a tick every cycle and with a tick every second cycle. A timer that counted clocks, or that was one tick off at a slot boundary, would finish early or late and would misplace the slot contents.

Further frames cover the remaining corner cases:
- A request above 16 bits: a design without the clamp would report the wrong `nbits`.
- A request of zero bits: it must still wait the full lead time.
- A stray `start` during a reception: a design that accepted it would change `nbits`.
- An input already high at frame start: a design that did not reset the compared level would miss the extra edge that lifts a count of 20 into the 1 band.
- Decryption: the number of keystream steps and the order in which mask bits are taken would show up as a wrong count and a wrong `word`.

// File: rtl/demod_pkg.sv
`timescale 1ns/1ps
package demod_pkg;

    // Keystream steps discarded before any mask bit is taken.
    localparam int KS_LEAD = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKIP,
        ST_GRAB,
        ST_WAIT,
        ST_WIN,
        ST_DONE
    } demod_state_t;

endpackage

// File: rtl/demod_sync.sv
`timescale 1ns/1ps
module demod_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/demod_window_timer.sv
`timescale 1ns/1ps
module demod_window_timer #(
    parameter int WAIT_TICKS = 490,
    parameter int BIT_TICKS  = 150,
    parameter int TW         = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic win_open,
    output logic win_close
);
    logic [TW-1:0] cnt_q;
    logic          win_q;

    assign win_open  = run && tick && !win_q && (cnt_q == TW'(WAIT_TICKS - 1));
    assign win_close = run && tick &&  win_q && (cnt_q == TW'(BIT_TICKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            win_q <= 1'b0;
        end else if (clear) begin
            cnt_q <= '0;
            win_q <= 1'b0;
        end else if (run && tick) begin
            if (win_open || win_close) begin
                cnt_q <= '0;
                win_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + TW'(1);
            end
        end
    end

    AST_SLOT_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        win_q |-> (cnt_q < TW'(BIT_TICKS))); // R2
    AST_LEAD_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !win_q |-> (cnt_q < TW'(WAIT_TICKS))); // R2
endmodule

// File: rtl/demod_edge_counter.sv
`timescale 1ns/1ps
module demod_edge_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             active,
    input  logic             restart,
    input  logic             lvl,
    output logic [CNT_W-1:0] total
);
    logic             prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic             edge_now;

    assign edge_now = active && (lvl != prev_q);
    assign total    = (edge_now && (cnt_q != '1)) ? cnt_q + CNT_W'(1) : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            cnt_q  <= '0;
        end else if (clear) begin
            prev_q <= 1'b0;
            cnt_q  <= '0;
        end else if (active) begin
            prev_q <= lvl;
            cnt_q  <= restart ? '0 : total;
        end
    end

    AST_COUNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !restart && !clear) |=> (cnt_q >= $past(cnt_q))); // R3
endmodule

// File: rtl/subcarrier_edge_demod.sv
`timescale 1ns/1ps
module subcarrier_edge_demod
    import demod_pkg::*;
#(
    parameter int WAIT_TICKS = 490,
    parameter int BIT_TICKS  = 150,
    parameter int EDGE_LO    = 20,
    parameter int EDGE_HI    = 60,
    parameter int MAX_BITS   = 16,
    parameter int CNT_W      = 8,
    localparam int IDX_W     = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                start,
    input  logic [IDX_W-1:0]    req_bits,
    input  logic                decrypt,
    input  logic                rx_raw,
    input  logic                ks_bit,
    output logic                ks_step,
    output logic [MAX_BITS-1:0] word,
    output logic [IDX_W-1:0]    nbits,
    output logic                done,
    output logic                tick_clear
);
    localparam int SEL_W = $clog2(MAX_BITS);
    localparam int TMR_W = $clog2(WAIT_TICKS + BIT_TICKS);

    demod_state_t        state_q, state_d;
    logic [IDX_W-1:0]    n_q, idx_q, n_last, req_clamped;
    logic [SEL_W-1:0]    idx_sel;
    logic                dec_q;
    logic [MAX_BITS-1:0] word_q;
    logic                rx_sync, win_open, win_close, bit_one;
    logic                accept, timer_run, slot_active;
    logic [CNT_W-1:0]    edge_total;

    assign req_clamped = (req_bits > IDX_W'(MAX_BITS)) ? IDX_W'(MAX_BITS) : req_bits;
    assign n_last      = n_q - IDX_W'(1);
    assign idx_sel     = idx_q[SEL_W-1:0];
    assign accept      = (state_q == ST_IDLE) && start;
    assign timer_run   = (state_q == ST_SKIP) || (state_q == ST_GRAB) ||
                         (state_q == ST_WAIT) || (state_q == ST_WIN);
    assign slot_active = (state_q == ST_WIN);
    assign bit_one     = (edge_total > CNT_W'(EDGE_LO)) && (edge_total < CNT_W'(EDGE_HI));

    demod_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_raw),
        .q     (rx_sync)
    );

    demod_window_timer #(
        .WAIT_TICKS (WAIT_TICKS),
        .BIT_TICKS  (BIT_TICKS),
        .TW         (TMR_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .run       (timer_run),
        .tick      (tick_en),
        .win_open  (win_open),
        .win_close (win_close)
    );

    demod_edge_counter #(.CNT_W(CNT_W)) u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .active  (slot_active),
        .restart (win_close),
        .lvl     (rx_sync),
        .total   (edge_total)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SKIP;
            ST_SKIP: if (idx_q == IDX_W'(KS_LEAD - 1))
                         state_d = (dec_q && (n_q != '0)) ? ST_GRAB : ST_WAIT;
            ST_GRAB: if (idx_q == n_last) state_d = ST_WAIT;
            ST_WAIT: if (win_open) state_d = (n_q == '0) ? ST_DONE : ST_WIN;
            ST_WIN:  if (win_close && (idx_q == n_last)) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q    <= '0;
            dec_q  <= 1'b0;
            word_q <= '0;
            idx_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    n_q    <= req_clamped;
                    dec_q  <= decrypt;
                    word_q <= '0;
                    idx_q  <= '0;
                end
                ST_SKIP: idx_q <= (idx_q == IDX_W'(KS_LEAD - 1)) ? '0 : idx_q + IDX_W'(1);
                ST_GRAB: begin
                    word_q[idx_sel] <= ks_bit;
                    idx_q <= (idx_q == n_last) ? '0 : idx_q + IDX_W'(1);
                end
                ST_WIN: if (win_close) begin
                    word_q[idx_sel] <= word_q[idx_sel] ^ bit_one;
                    idx_q <= idx_q + IDX_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ks_step    = (state_q == ST_SKIP) || (state_q == ST_GRAB);
        done       = (state_q == ST_DONE);
        tick_clear = (state_q == ST_DONE);
        word       = word_q;
        nbits      = n_q;
    end

    AST_NO_OPEN_DURING_KS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SKIP) || (state_q == ST_GRAB)) |-> !win_open); // R2
    AST_SLOT_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WIN) |-> (idx_q < n_q)); // R5
    AST_NBITS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q <= IDX_W'(MAX_BITS))); // R5
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && start) |=> $stable(n_q)); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
endmodule

// File: tb/test_subcarrier_edge_demod.sv
`timescale 1ns/1ps
module test_subcarrier_edge_demod;
    localparam int IW = 5;

    logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b1, start = 1'b0;
    logic        decrypt = 1'b0, rx_raw = 1'b0, ks_load = 1'b0;
    logic [IW-1:0] req_bits = '0;
    logic        ks_bit, ks_step, done, tick_clear;
    logic [IW-1:0] nbits;
    logic [15:0] word;
    logic [7:0]  lfsr = 8'h01, ks_seed = 8'h01;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    subcarrier_edge_demod i_subcarrier_edge_demod (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start),
        .req_bits(req_bits), .decrypt(decrypt), .rx_raw(rx_raw), .ks_bit(ks_bit),
        .ks_step(ks_step), .word(word), .nbits(nbits), .done(done), .tick_clear(tick_clear)
    );

    function automatic logic [7:0] nx(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    always @(posedge clk) begin
        if (ks_load)      lfsr <= ks_seed;
        else if (ks_step) lfsr <= nx(lfsr);
    end
    assign ks_bit = lfsr[0];

    // Table: {n[31:27], decrypt[26], style[25:24], seed[23:16], raw[15:0]}
    localparam logic [31:0] VEC [0:7] = '{
        {5'd16, 1'b0, 2'd0, 8'h00, 16'hA5C3},
        {5'd12, 1'b1, 2'd0, 8'h5A, 16'h00F3},
        {5'd6,  1'b1, 2'd1, 8'h81, 16'h002D},
        {5'd16, 1'b0, 2'd2, 8'h00, 16'h8001},
        {5'd20, 1'b0, 2'd0, 8'h00, 16'hFFFF},
        {5'd0,  1'b1, 2'd0, 8'h77, 16'h0000},
        {5'd1,  1'b0, 2'd3, 8'h00, 16'h0001},
        {5'd9,  1'b1, 2'd3, 8'hC7, 16'h0155}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int clampn(input int n);
        return (n > 16) ? 16 : n;
    endfunction

    function automatic logic [15:0] exp_word(input int n, input bit dec,
                                             input logic [7:0] seed, input logic [15:0] raw);
        logic [7:0]  s;
        logic [15:0] m;
        logic [15:0] r;
        int nc;
        nc = clampn(n);
        s = nx(nx(seed));
        m = '0;
        r = raw;
        if (dec) for (int i = 0; i < nc; i++) begin m[i] = s[0]; s = nx(s); end
        for (int i = nc; i < 16; i++) r[i] = 1'b0;
        return r ^ m;
    endfunction

    function automatic int ecount(input bit b, input int style, input int i);
        case (style)
            0:       return b ? 42 : 0;
            1:       return b ? 21 : 20;
            2:       return b ? 59 : 60;
            default: return b ? ((i % 2 != 0) ? 30 : 50) : ((i % 2 != 0) ? 1 : 61);
        endcase
    endfunction

    function automatic bit tog(input int k, input int p, input int nc, input int style,
                               input logic [15:0] raw);
        int base, wl, i, off;
        base = p * 490;
        wl = 150 * p;
        if (k < base) return 1'b0;
        i = (k - base) / wl;
        off = (k - base) % wl;
        if (i >= nc) return 1'b0;
        if (off < 10 || (off % 2) != 0) return 1'b0;
        return ((off - 10) / 2) < ecount(raw[i], style, i);
    endfunction

    task automatic run_frame(input int nreq, input bit dec, input int style,
                             input logic [7:0] seed, input logic [15:0] drive_raw,
                             input logic [15:0] expw, input int p, input bit inject,
                             input bit init_lvl);
        int nc, k, donek, steps, clr_cnt, limit;
        bit clr_at_done;
        logic [15:0] wgot;
        logic [IW-1:0] ngot;
        nc = clampn(nreq);
        donek = -1; steps = 0; clr_cnt = 0; clr_at_done = 1'b0;
        wgot = 'x; ngot = 'x;
        limit = p * (490 + 150 * 16) + 20;
        @(posedge clk); #1;
        ks_seed = seed; ks_load = 1'b1; rx_raw = init_lvl; tick_en = (p == 1);
        @(posedge clk); #1;
        ks_load = 1'b0; start = 1'b1; req_bits = IW'(nreq); decrypt = dec;
        @(posedge clk); #1;
        start = 1'b0;
        k = 0;
        while (k < limit && donek < 0) begin
            if (ks_step) steps++;
            if (tick_clear) clr_cnt++;
            if (done) begin
                donek = k; clr_at_done = tick_clear; wgot = word; ngot = nbits;
            end else begin
                tick_en = ((k + 1) % p == 0);
                if (inject && k == p * 490 + 5) begin
                    start = 1'b1; req_bits = IW'(3); decrypt = ~dec;
                end else begin
                    start = 1'b0;
                end
                if (tog(k, p, nc, style, drive_raw)) rx_raw = ~rx_raw;
                @(posedge clk); #1;
                k++;
            end
        end
        chk(donek == p * (490 + 150 * nc), "R2 done cycle", donek, p * (490 + 150 * nc));
        chk(wgot == expw, "R4/R6/R8 word", int'(wgot), int'(expw));
        chk(ngot == IW'(nc), "R5 nbits", int'(ngot), nc);
        chk(steps == 2 + (dec ? nc : 0), "R7 ks_step count", steps, 2 + (dec ? nc : 0));
        chk(clr_at_done && clr_cnt == 1, "R9 tick_clear with done", clr_cnt, 1);
        start = 1'b0;
        tick_en = 1'b1;
        @(posedge clk); #1;
        chk(!done && !tick_clear, "R9 single-cycle done", int'(done), 0);
        chk(word == expw && nbits == IW'(nc), "R1 outputs held", int'(word), int'(expw));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk(!done && !tick_clear && !ks_step && word == '0 && nbits == '0,
            "R10 in reset", int'(word), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!done && !tick_clear && !ks_step && word == '0 && nbits == '0,
            "R10 after reset", int'(nbits), 0);

        for (int v = 0; v < 8; v++) begin
            logic [31:0] e;
            e = VEC[v];
            run_frame(int'(e[31:27]), e[26], int'(e[25:24]), e[23:16], e[15:0],
                      exp_word(int'(e[31:27]), e[26], e[23:16], e[15:0]), 1, 1'b0, 1'b0);
        end

        // R2: ticks every second cycle
        run_frame(4, 1'b1, 0, 8'h3C, 16'h000A, exp_word(4, 1'b1, 8'h3C, 16'h000A), 2, 1'b0, 1'b0);
        // R1: stray start during reception is ignored
        run_frame(5, 1'b0, 0, 8'h00, 16'h0013, exp_word(5, 1'b0, 8'h00, 16'h0013), 1, 1'b1, 1'b0);
        // R3: input high at frame start adds one edge in slot 0 (20 -> 21 gives a 1)
        run_frame(2, 1'b0, 1, 8'h00, 16'h0000, 16'h0001, 1, 1'b0, 1'b1);
        rx_raw = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule